// File: doc/BRIEF.md
# Sync-Word Byte Deframer

This block sits after a demodulator and clock-recovery stage. It takes a recovered serial bit stream, one bit per cycle in which a bit strobe is high, and watches the most recent sixteen bits for any of three synchronisation patterns. One pattern is programmable from an input word. The other two are fixed constants. Each pattern has its own status flag.

A match restarts byte framing so that the next byte begins with the bit after the pattern. It also restarts the running CRC-16. From then on every eighth bit completes a byte. That byte goes into a receive-data register and raises a byte-ready flag. The byte-ready flag keeps firing every eight bits even when no message is present, so the host must use the sync flags and the checksum flag to decide which bytes are valid.

A message ends with a two-byte CRC. The checksum-OK flag is meaningful only at the byte event of the second CRC byte. The host must know the message length to pick that moment. All flags are sticky until the host pulses a status read, and an active-low interrupt is asserted while any flag is set.

Top module: `sync_deframer`

## Requirements
- R1: Each sync pattern has its own flag: the programmable word sets status[0], fixed word 16'h3B28 sets status[1], fixed word 16'hC4D7 sets status[2]. A pattern matches when the last sixteen accepted bits equal it, with the earliest bit as bit 15 of the word.
- R2: No pattern is reported until at least sixteen bits have been accepted since reset.
- R3: Any pattern match resets the CRC register to 16'hFFFF.
- R4: status[3] (byte ready) is set on every eighth accepted bit. A match restarts the count, so the next byte event falls on the eighth bit after the pattern's last bit. A bit that completes a match raises no byte event.
- R5: At a byte event, rx_data takes the last eight accepted bits, with the earliest bit in bit 7. An unread byte is overwritten by the next one.
- R6: At each byte event, status[4] (checksum OK) is set when the CRC-16 over all bytes since the match, including this byte, is zero. The CRC uses polynomial 16'h1021, initial value 16'hFFFF, MSB first and no final inversion. The sender appends the CRC high byte first.
- R7: A one-cycle status_rd pulse clears all flags. A flag set in that same cycle stays set. Without a read, a set flag stays set.
- R8: irq_n is low exactly when any status bit is set. After reset, status, rx_data and the CRC state are zero, zero and 16'hFFFF, and irq_n is high.
- R9: Bit values presented while bit_valid is low have no effect on framing, data or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Strobe marking a cycle that carries a received bit |
| bit_in | input | 1 | Received bit value |
| prog_word | input | 16 | Programmable sync pattern |
| status_rd | input | 1 | Status read pulse; clears the flags |
| status | output | 5 | {checksum OK, byte ready, fixed B, fixed A, programmable} |
| rx_data | output | 8 | Last completed byte |
| irq_n | output | 1 | Active-low interrupt, low while any flag is set |

## Verification
All results are registered on the same rising edge that accepts the bit completing them: the sync flags, byte ready, checksum OK and rx_data. They are therefore visible one edge after the strobe is driven. The bench drives each bit on a falling edge, drops the strobe on the next falling edge, and samples the outputs at that point. Flag clearing by status_rd follows the same one-edge rule and is sampled in the same way. Messages built from every sync pattern and payload lengths zero to six are sent with correct and corrupted CRC bytes. At each byte, the expected checksum flag is recomputed arithmetically from the bytes sent so far.

// File: rtl/deframe_pkg.sv
package deframe_pkg;

    localparam int SYNC_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int NUM_SYNC = 3;
    localparam int CRC_W    = 16;
    localparam int STAT_W   = NUM_SYNC + 2;

    localparam logic [CRC_W-1:0]  CRC_POLY = 16'h1021;
    localparam logic [CRC_W-1:0]  CRC_INIT = 16'hFFFF;

    localparam logic [SYNC_W-1:0] FIXED_WORD_A = 16'h3B28;
    localparam logic [SYNC_W-1:0] FIXED_WORD_B = 16'hC4D7;

    // status layout: {sum_ok, byte_rdy, sync[2:0]}
    typedef struct packed {
        logic                sum_ok;
        logic                byte_rdy;
        logic [NUM_SYNC-1:0] sync;
    } status_t;

    function automatic logic [SYNC_W-1:0] fixed_word(input int idx);
        return (idx == 1) ? FIXED_WORD_A : FIXED_WORD_B;
    endfunction

    // one byte into the CRC, MSB first
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic [BYTE_W-1:0] d);
        logic [CRC_W-1:0] r;
        logic             fb;
        r = c;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            fb = r[CRC_W-1] ^ d[i];
            r  = {r[CRC_W-2:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/sync_matcher.sv
module sync_matcher
    import deframe_pkg::*;
#(
    parameter int W = SYNC_W,
    parameter int N = NUM_SYNC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bit_valid,
    input  logic         bit_in,
    input  logic [W-1:0] prog_word,
    output logic [W-1:0] shift_next,
    output logic [N-1:0] hit_vec
);
    localparam int FILL_CW = $clog2(W);
    localparam logic [FILL_CW-1:0] FILL_LAST = FILL_CW'(W - 1);

    logic [W-1:0]       shift_q;
    logic [FILL_CW-1:0] fill_q;
    logic               filled_now;

    assign shift_next = {shift_q[W-2:0], bit_in};
    assign filled_now = bit_valid && (fill_q == FILL_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            fill_q  <= '0;
        end else if (bit_valid) begin
            shift_q <= shift_next;
            if (fill_q != FILL_LAST) fill_q <= fill_q + 1'b1;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_cmp
        logic [W-1:0] word;
        if (i == 0) begin : g_prog
            assign word = prog_word;
        end else begin : g_fixed
            assign word = fixed_word(i);
        end
        assign hit_vec[i] = filled_now && (shift_next == word);
    end

    // R9: shift history holds while no bit is offered
    p_shift_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |=> shift_q == $past(shift_q));

endmodule

// File: rtl/byte_framer.sv
module byte_framer
    import deframe_pkg::*;
#(
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_valid,
    input  logic          sync_any,
    input  logic [BW-1:0] byte_in,
    output logic          byte_evt,
    output logic [BW-1:0] rx_data
);
    localparam int CNT_W = $clog2(BW);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BW - 1);

    logic [CNT_W-1:0] cnt_q;

    assign byte_evt = bit_valid && !sync_any && (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            rx_data <= '0;
        end else if (bit_valid) begin
            if (sync_any || cnt_q == CNT_LAST) cnt_q <= '0;
            else                               cnt_q <= cnt_q + 1'b1;
            if (byte_evt) rx_data <= byte_in;
        end
    end

    // R4: a match restarts byte framing
    p_realign_r4: assert property (@(posedge clk) disable iff (rst)
        bit_valid && sync_any |=> cnt_q == '0);

    // R5: completed byte appears in the data register
    p_data_latch_r5: assert property (@(posedge clk) disable iff (rst)
        byte_evt |=> rx_data == $past(byte_in));

endmodule

// File: rtl/crc_checker.sv
module crc_checker
    import deframe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_any,
    input  logic              byte_evt,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              sum_ok_evt
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_nx;

    assign crc_nx     = crc_step(crc_q, byte_in);
    assign sum_ok_evt = byte_evt && (crc_nx == '0);

    always_ff @(posedge clk) begin
        if (rst || sync_any) crc_q <= CRC_INIT;
        else if (byte_evt)   crc_q <= crc_nx;
    end

    // R3: a pattern match restarts the checksum
    p_crc_restart_r3: assert property (@(posedge clk) disable iff (rst)
        sync_any |=> crc_q == CRC_INIT);

endmodule

// File: rtl/status_flags.sv
module status_flags
    import deframe_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  status_t set,
    input  logic    rd,
    output status_t flags
);
    always_ff @(posedge clk) begin
        if (rst)     flags <= '0;
        else if (rd) flags <= set;
        else         flags <= flags | set;
    end

    // R7: a read with nothing new leaves all flags clear
    p_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
        rd && (set == '0) |=> flags == '0);

    // R7: flags are sticky without a read
    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        !rd |=> (flags & $past(flags)) == $past(flags));

endmodule

// File: rtl/sync_deframer.sv
module sync_deframer
    import deframe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic [SYNC_W-1:0] prog_word,
    input  logic              status_rd,
    output logic [STAT_W-1:0] status,
    output logic [BYTE_W-1:0] rx_data,
    output logic              irq_n
);
    logic [SYNC_W-1:0]   shift_next;
    logic [NUM_SYNC-1:0] hit_vec;
    logic                sync_any;
    logic                byte_evt;
    logic                sum_ok_evt;
    status_t             set_v;
    status_t             flags;

    sync_matcher #(.W(SYNC_W), .N(NUM_SYNC)) u_match (
        .clk        (clk),
        .rst        (rst),
        .bit_valid  (bit_valid),
        .bit_in     (bit_in),
        .prog_word  (prog_word),
        .shift_next (shift_next),
        .hit_vec    (hit_vec)
    );

    assign sync_any = |hit_vec;

    byte_framer #(.BW(BYTE_W)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .bit_valid (bit_valid),
        .sync_any  (sync_any),
        .byte_in   (shift_next[BYTE_W-1:0]),
        .byte_evt  (byte_evt),
        .rx_data   (rx_data)
    );

    crc_checker u_crc (
        .clk        (clk),
        .rst        (rst),
        .sync_any   (sync_any),
        .byte_evt   (byte_evt),
        .byte_in    (shift_next[BYTE_W-1:0]),
        .sum_ok_evt (sum_ok_evt)
    );

    always_comb begin
        set_v.sum_ok   = sum_ok_evt;
        set_v.byte_rdy = byte_evt;
        set_v.sync     = hit_vec;
    end

    status_flags u_flags (
        .clk   (clk),
        .rst   (rst),
        .set   (set_v),
        .rd    (status_rd),
        .flags (flags)
    );

    assign status = flags;
    assign irq_n  = ~|flags;

    // R4: the checksum flag only rises together with a byte event
    p_sum_with_byte_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.sum_ok) |-> flags.byte_rdy);

endmodule

// File: tb/sync_deframer_bench.sv
module sync_deframer_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        bit_valid;
    logic        bit_in;
    logic [15:0] prog_word;
    logic        status_rd;
    logic [4:0]  status;
    logic [7:0]  rx_data;
    logic        irq_n;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    localparam logic [15:0] WA = 16'h3B28;
    localparam logic [15:0] WB = 16'hC4D7;
    localparam logic [15:0] WP = 16'hA5F0;

    always #5 clk = ~clk;

    sync_deframer u_sync_deframer (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
        .prog_word(prog_word), .status_rd(status_rd), .status(status),
        .rx_data(rx_data), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_valid = 1'b1;
        bit_in    = b;
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d);
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
    endtask

    task automatic read_status();
        @(negedge clk);
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
    endtask

    function automatic logic [15:0] crc_upd(input logic [15:0] c,
                                            input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction

    task automatic run_msg(input int widx, input int len, input bit corrupt);
        logic [7:0]  pl[0:9];
        logic        st[0:127];
        logic [15:0] w, c, win;
        int          n;
        bit          clash;
        w = (widx == 0) ? WP : (widx == 1) ? WA : WB;
        c = 16'hFFFF;
        for (int i = 0; i < len; i++) begin
            pl[i] = 8'(i * 37 + len * 11 + widx * 5 + 1);
            c = crc_upd(c, pl[i]);
        end
        pl[len]     = c[15:8];
        pl[len + 1] = c[7:0] ^ (corrupt ? 8'h01 : 8'h00);
        n = 0;
        for (int i = 0; i < 16; i++) begin st[n] = 1'b0; n++; end
        for (int i = 15; i >= 0; i--) begin st[n] = w[i]; n++; end
        for (int k = 0; k < len + 2; k++)
            for (int i = 7; i >= 0; i--) begin st[n] = pl[k][i]; n++; end
        clash = 0;
        for (int e = 15; e < n; e++) begin
            for (int i = 0; i < 16; i++) win[15 - i] = st[e - 15 + i];
            if (e != 31 && (win == WP || win == WA || win == WB)) clash = 1;
        end
        if (clash) return;

        for (int i = 0; i < 16; i++) send_bit(1'b0);
        read_status();
        for (int i = 15; i >= 0; i--) send_bit(w[i]);
        check("R1 sync flag", {29'd0, status[2:0]}, 32'(1 << widx));
        check("R8 irq low on flag", {31'd0, irq_n}, 0);
        read_status();
        check("R7 read clears", {27'd0, status}, 0);
        check("R8 irq high when clear", {31'd0, irq_n}, 1);
        c = 16'hFFFF;
        for (int k = 0; k < len + 2; k++) begin
            for (int i = 7; i >= 1; i--) send_bit(pl[k][i]);
            check("R4 no byte before 8th bit", {31'd0, status[3]}, 0);
            send_bit(pl[k][0]);
            c = crc_upd(c, pl[k]);
            check("R4 byte ready on 8th bit", {31'd0, status[3]}, 1);
            check("R5 byte value", {24'd0, rx_data}, {24'd0, pl[k]});
            check("R6 checksum flag", {31'd0, status[4]}, {31'd0, (c == 16'h0)});
            if (k == len + 1)
                check("R6 final checksum verdict", {31'd0, status[4]},
                      corrupt ? 0 : 1);
            read_status();
        end
    endtask

    initial begin
        rst = 1'b1; bit_valid = 1'b0; bit_in = 1'b0;
        prog_word = 16'h0000; status_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8 reset status", {27'd0, status}, 0);
        check("R8 reset data", {24'd0, rx_data}, 0);
        check("R8 reset irq", {31'd0, irq_n}, 1);

        // R2: zero pattern not reported before sixteen bits
        for (int i = 0; i < 15; i++) send_bit(1'b0);
        check("R2 no match before fill", {31'd0, status[0]}, 0);
        send_bit(1'b0);
        check("R2 match at sixteenth bit", {31'd0, status[0]}, 1);
        prog_word = WP;
        read_status();

        for (int widx = 0; widx < 3; widx++)
            for (int len = 0; len < 7; len++) begin
                run_msg(widx, len, 1'b0);
                run_msg(widx, len, 1'b1);
            end

        // R5 overwrite and R9 ignored bits
        for (int i = 0; i < 16; i++) send_bit(1'b0);
        for (int i = 15; i >= 0; i--) send_bit(WA[i]);
        read_status();
        send_byte(8'h12);
        for (int i = 7; i >= 4; i--) send_bit(8'h34 >> i);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            bit_in = ~bit_in;
        end
        @(negedge clk);
        check("R9 no flag change on idle bits", {31'd0, status[3]}, 1);
        check("R9 data unchanged", {24'd0, rx_data}, 32'h12);
        for (int i = 3; i >= 0; i--) send_bit(8'h34 >> i);
        check("R5 overwrite unread byte", {24'd0, rx_data}, 32'h34);
        check("R9 framing kept", {31'd0, status[3]}, 1);
        read_status();

        // R7: set in read cycle wins
        for (int i = 7; i >= 1; i--) send_bit(8'h5A >> i);
        @(negedge clk);
        bit_valid = 1'b1; bit_in = 1'b0; status_rd = 1'b1;
        @(negedge clk);
        bit_valid = 1'b0; status_rd = 1'b0;
        check("R7 set beats read", {31'd0, status[3]}, 1);
        check("R7 others cleared", {29'd0, status[2:0]}, 0);
        check("R5 byte in read cycle", {24'd0, rx_data}, 32'h5A);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule